// File: doc/BRIEF.md
# Structured-Sparse Dot-Product Slice

This slice computes a signed dot product between a stream of compressed weights and dense activation vectors. Each beat carries eight kept weight values and a 2-bit position code for each of them. The slice turns those codes into activation positions, multiplies only the kept weights by the activations they point at, and adds the beat's products into a 32-bit accumulator. A dot product is a run of beats. The first beat is marked as the start and the final beat as the last.

A small mode register picks how the position codes are read: dense, two kept out of every four, one kept out of every three, or one kept out of every four. The same eight multipliers serve all four patterns. Only the activation selection changes, so a beat covers 8, 16, 24 or 32 activation slots depending on the mode. The mode can only change between dot products. In the one-of-three pattern a code of 3 has no position to point at, so the slice flags it.

Top module: `sparse_dot_slice`

## Requirements
- R1: After reset, acc_out is 0, acc_valid is 0, idx_err is 0 and mode_q reads 0 (dense).
- R2: Mode code 0 (dense): lane k multiplies weight k by activation slot k, and the position codes are not used.
- R3: Mode code 1 (two of four): lane k multiplies by activation slot 4*(k/2) + code_k. Lanes 2j and 2j+1 share group j.
- R4: Mode code 2 (one of three): lane k multiplies by activation slot 3*k + code_k, for codes 0 to 2.
- R5: Mode code 3 (one of four): lane k multiplies by activation slot 4*k + code_k.
- R6: In mode 2, a lane whose code is 3 adds zero to the sum. idx_err goes high in the cycle after that beat, and stays low after beats with no such lane. idx_err never rises in any other mode.
- R7: A beat with grp_start set replaces the accumulator with that beat's sum. Other beats add their sum to the accumulator.
- R8: acc_valid is high for exactly the one cycle after a beat marked grp_last, and acc_out then holds the total. acc_valid stays low after beats that are not last.
- R9: A mode write while the slice is idle shows on mode_q in the next cycle. A write during a beat, or between the start beat and the last beat, is ignored.
- R10: Weights and activations are signed 8-bit two's complement values, and the accumulator is signed 32-bit. Extreme operands such as -128 times -128 and -128 times 127 give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_in | input | 2 | Mode to write: 0 dense, 1 two-of-four, 2 one-of-three, 3 one-of-four |
| mode_q | output | 2 | Current mode register value |
| grp_valid | input | 1 | A weight beat is present this cycle |
| grp_start | input | 1 | Beat is the first of a dot product; clears the accumulator |
| grp_last | input | 1 | Beat is the last of a dot product |
| wt_val | input | 64 | Eight signed 8-bit kept weights; lane k at bits 8k+7:8k |
| wt_idx | input | 16 | Eight 2-bit position codes; lane k at bits 2k+1:2k |
| act_vec | input | 256 | Thirty-two signed 8-bit activation slots; slot s at bits 8s+7:8s |
| acc_out | output | 32 | Signed accumulator |
| acc_valid | output | 1 | One-cycle pulse: acc_out holds a finished dot product |
| idx_err | output | 1 | Previous beat had a one-of-three code of 3 |

## Verification
If a lane points at the wrong slot, the result is wrong in the cycle after the last beat. The bench therefore fills every activation slot with distinct random values, so a wrong pick in any mode changes the total. If the busy state or the mode register is wrong, a blocked write shows at once on mode_q, and the rest of the product is then computed in the wrong pattern. If the accumulator is not cleared on a start beat, the next total is wrong. A stale valid or error flag shows as a second cycle of acc_valid or idx_err after the beat that caused it.

// File: rtl/sds_pkg.sv
package sds_pkg;

  typedef enum logic [1:0] {
    MD_DENSE = 2'd0,
    MD_2OF4  = 2'd1,
    MD_1OF3  = 2'd2,
    MD_1OF4  = 2'd3
  } sds_mode_e;

  // Activation slot a lane reads, given the pattern and its position code.
  function automatic int unsigned act_pos(sds_mode_e m, int unsigned lane, logic [1:0] code);
    case (m)
      MD_DENSE: return lane;
      MD_2OF4:  return (lane / 2) * 4 + 32'(code);
      MD_1OF3:  return lane * 3 + 32'(code);
      default:  return lane * 4 + 32'(code);
    endcase
  endfunction

  // A code of 3 names no slot in a group of three.
  function automatic logic code_legal(sds_mode_e m, logic [1:0] code);
    return !(m == MD_1OF3 && code == 2'd3);
  endfunction

endpackage

// File: rtl/sds_lane_select.sv
module sds_lane_select
  import sds_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int OP_W   = 8,
  parameter int ACT_N  = 32,
  parameter int PROD_W = 2 * OP_W
) (
  input  sds_mode_e                 mode,
  input  logic [LANES*OP_W-1:0]     wts,
  input  logic [LANES*2-1:0]        codes,
  input  logic [ACT_N*OP_W-1:0]     acts,
  output logic [LANES*PROD_W-1:0]   prods,
  output logic [LANES-1:0]          bad
);
  localparam int POS_W = (ACT_N > 1) ? $clog2(ACT_N) : 1;

  logic [OP_W-1:0] act_arr [ACT_N];

  for (genvar s = 0; s < ACT_N; s++) begin : g_unpack
    assign act_arr[s] = acts[s*OP_W +: OP_W];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int unsigned              pos_l;
    logic [POS_W-1:0]         sel_l;
    logic [OP_W-1:0]          a_l;
    logic                     ok_l;
    logic signed [PROD_W-1:0] p_l;

    always_comb begin
      pos_l = act_pos(mode, l, codes[2*l +: 2]);
      sel_l = POS_W'(pos_l);
      a_l   = (pos_l < ACT_N) ? act_arr[sel_l] : '0;
      ok_l  = code_legal(mode, codes[2*l +: 2]);
      p_l   = $signed(wts[l*OP_W +: OP_W]) * $signed(a_l);
      prods[l*PROD_W +: PROD_W] = ok_l ? p_l : '0;
      bad[l] = !ok_l;
    end
  end

  // A pruned or illegal lane contributes nothing to the beat.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      AST_BAD_LANE_ZERO: assert (!bad[l] || prods[l*PROD_W +: PROD_W] == '0); // R6
    end
  end

endmodule

// File: rtl/sds_mode_ctrl.sv
module sds_mode_ctrl
  import sds_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_wr,
  input  logic [1:0] mode_in,
  input  logic      beat,
  input  logic      last,
  output sds_mode_e mode_q,
  output logic      busy_q,
  output logic      mode_take
);
  // Named event: a write that is allowed to land.
  assign mode_take = mode_wr && !busy_q && !beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_DENSE;
      busy_q <= 1'b0;
    end else begin
      if (mode_take) mode_q <= sds_mode_e'(mode_in);
      if (beat)      busy_q <= !last;
    end
  end

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q || beat) |=> $stable(mode_q)); // R9

  AST_MODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_take |=> (mode_q == $past(mode_in))); // R9

endmodule

// File: rtl/sparse_dot_slice.sv
module sparse_dot_slice
  import sds_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OP_W  = 8,
  parameter int ACC_W = 32,
  parameter int CODE_SPAN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mode_wr,
  input  logic [1:0]                   mode_in,
  output logic [1:0]                   mode_q,
  input  logic                         grp_valid,
  input  logic                         grp_start,
  input  logic                         grp_last,
  input  logic [LANES*OP_W-1:0]        wt_val,
  input  logic [LANES*2-1:0]           wt_idx,
  input  logic [LANES*CODE_SPAN*OP_W-1:0] act_vec,
  output logic [ACC_W-1:0]             acc_out,
  output logic                         acc_valid,
  output logic                         idx_err
);
  localparam int ACT_N  = LANES * CODE_SPAN;
  localparam int PROD_W = 2 * OP_W;

  sds_mode_e                mode_r;
  logic                     busy_q;
  logic                     mode_take;
  logic [LANES*PROD_W-1:0]  prods;
  logic [LANES-1:0]         bad;
  logic signed [ACC_W-1:0]  beat_sum;
  logic signed [ACC_W-1:0]  acc_q;
  logic                     beat;
  logic                     beat_bad;

  assign beat = grp_valid;

  sds_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_in   (mode_in),
    .beat      (beat),
    .last      (grp_last),
    .mode_q    (mode_r),
    .busy_q    (busy_q),
    .mode_take (mode_take)
  );

  sds_lane_select #(
    .LANES  (LANES),
    .OP_W   (OP_W),
    .ACT_N  (ACT_N),
    .PROD_W (PROD_W)
  ) u_lanes (
    .mode  (mode_r),
    .wts   (wt_val),
    .codes (wt_idx),
    .acts  (act_vec),
    .prods (prods),
    .bad   (bad)
  );

  always_comb begin
    beat_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      beat_sum = beat_sum + ACC_W'($signed(prods[l*PROD_W +: PROD_W]));
    end
  end

  assign beat_bad = beat && (|bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      acc_valid <= 1'b0;
      idx_err   <= 1'b0;
    end else begin
      acc_valid <= beat && grp_last;
      idx_err   <= beat_bad;
      if (beat) acc_q <= (grp_start ? '0 : acc_q) + beat_sum;
    end
  end

  assign acc_out = acc_q;
  assign mode_q  = mode_r;

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && grp_last) |=> acc_valid); // R8

  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(beat && grp_last)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && grp_start) |=> (acc_q == $past(beat_sum))); // R7

  AST_ERR_ONLY_1OF3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> $past(mode_r == MD_1OF3)); // R6

  AST_ACC_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(acc_q)); // R7

endmodule

// File: tb/tb_sparse_dot_slice.sv
module tb_sparse_dot_slice;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_wr = 1'b0;
  logic [1:0]   mode_in = '0;
  logic [1:0]   mode_q;
  logic         grp_valid = 1'b0, grp_start = 1'b0, grp_last = 1'b0;
  logic [63:0]  wt_val = '0;
  logic [15:0]  wt_idx = '0;
  logic [255:0] act_vec = '0;
  logic [31:0]  acc_out;
  logic         acc_valid, idx_err;

  int errors = 0, checks = 0;
  bit done = 0;
  logic signed [31:0] exp_acc = '0;
  int w [8];
  int ix [8];
  int a [32];

  always #4 clk = ~clk;

  sparse_dot_slice dut (.*);

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int md);
    int s = 0;
    for (int k = 0; k < 8; k++) begin
      int p;
      if (md == 0) p = k;
      else if (md == 1) p = ((k >> 1) << 2) + ix[k];
      else if (md == 2) p = 3 * k + ix[k];
      else p = (k << 2) + ix[k];
      if (!(md == 2 && ix[k] == 3)) s += w[k] * a[p];
    end
    return s;
  endfunction

  task automatic fill(int md);
    for (int k = 0; k < 8; k++) begin
      w[k]  = int'($urandom % 256) - 128;
      ix[k] = (md == 2) ? int'($urandom % 3) : int'($urandom % 4);
    end
    for (int s = 0; s < 32; s++) a[s] = int'($urandom % 256) - 128;
  endtask

  task automatic send(bit st, bit ls, int md);
    for (int k = 0; k < 8; k++) begin
      wt_val[8*k +: 8] = 8'(w[k]);
      wt_idx[2*k +: 2] = 2'(ix[k]);
    end
    for (int s = 0; s < 32; s++) act_vec[8*s +: 8] = 8'(a[s]);
    grp_valid = 1; grp_start = st; grp_last = ls;
    exp_acc = (st ? 32'sd0 : exp_acc) + 32'(model(md));
    @(negedge clk);
    grp_valid = 0; grp_start = 0; grp_last = 0;
  endtask

  task automatic set_mode(int md);
    mode_wr = 1; mode_in = 2'(md);
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic single(int md, string req);
    set_mode(md);
    chk(mode_q == 2'(md), "R9 mode write when idle", mode_q, md);
    fill(md);
    send(1, 1, md);
    chk(acc_valid == 1, req, acc_valid, 1);
    chk(acc_out == exp_acc, req, $signed(acc_out), exp_acc);
  endtask

  task automatic t_reset();
    chk(acc_out == 0, "R1 acc", acc_out, 0);
    chk(acc_valid == 0, "R1 valid", acc_valid, 0);
    chk(idx_err == 0, "R1 err", idx_err, 0);
    chk(mode_q == 0, "R1 mode", mode_q, 0);
  endtask

  task automatic t_modes();
    for (int r = 0; r < 3; r++) begin
      single(0, "R2 dense");
      single(1, "R3 two of four");
      single(2, "R4 one of three");
      single(3, "R5 one of four");
    end
    set_mode(0);
    fill(0);
    for (int k = 0; k < 8; k++) ix[k] = 3 - (k % 4);
    send(1, 1, 0);
    chk(acc_out == exp_acc, "R2 codes unused in dense", $signed(acc_out), exp_acc);
  endtask

  task automatic t_badidx();
    set_mode(2);
    fill(2);
    ix[1] = 3; ix[6] = 3;
    send(1, 1, 2);
    chk(idx_err == 1, "R6 err flag", idx_err, 1);
    chk(acc_out == exp_acc, "R6 bad lanes add zero", $signed(acc_out), exp_acc);
    fill(2);
    send(1, 1, 2);
    chk(idx_err == 0, "R6 err clears", idx_err, 0);
    set_mode(3);
    fill(3);
    for (int k = 0; k < 8; k++) ix[k] = 3;
    send(1, 1, 3);
    chk(idx_err == 0, "R6 no err in one of four", idx_err, 0);
    chk(acc_out == exp_acc, "R5 code 3", $signed(acc_out), exp_acc);
  endtask

  task automatic t_multi();
    set_mode(1);
    fill(1); send(1, 0, 1);
    chk(acc_valid == 0, "R8 no valid mid product", acc_valid, 0);
    fill(1); send(0, 0, 1);
    chk(acc_valid == 0, "R8 no valid mid product", acc_valid, 0);
    fill(1); send(0, 1, 1);
    chk(acc_valid == 1, "R8 valid after last", acc_valid, 1);
    chk(acc_out == exp_acc, "R7 three beat sum", $signed(acc_out), exp_acc);
    @(negedge clk);
    chk(acc_valid == 0, "R8 single cycle pulse", acc_valid, 0);
    chk(acc_out == exp_acc, "R8 result held", $signed(acc_out), exp_acc);
    fill(1); send(1, 1, 1);
    chk(acc_out == exp_acc, "R7 start clears", $signed(acc_out), exp_acc);
  endtask

  task automatic t_mode_lock();
    set_mode(1);
    fill(1);
    mode_wr = 1; mode_in = 2'd3;
    send(1, 0, 1);
    chk(mode_q == 1, "R9 write during beat ignored", mode_q, 1);
    mode_in = 2'd2;
    @(negedge clk);
    mode_wr = 0;
    chk(mode_q == 1, "R9 write while busy ignored", mode_q, 1);
    fill(1); send(0, 1, 1);
    chk(acc_out == exp_acc, "R9 product kept its mode", $signed(acc_out), exp_acc);
    set_mode(3);
    chk(mode_q == 3, "R9 write after last accepted", mode_q, 3);
  endtask

  task automatic t_extreme();
    set_mode(0);
    for (int k = 0; k < 8; k++) begin w[k] = -128; ix[k] = 0; end
    for (int s = 0; s < 32; s++) a[s] = -128;
    send(1, 0, 0);
    for (int s = 0; s < 32; s++) a[s] = 127;
    send(0, 1, 0);
    chk(acc_out == exp_acc, "R10 signed extremes", $signed(acc_out), exp_acc);
    chk(exp_acc == 32'sd1024, "R10 model value", exp_acc, 1024);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_modes();
    t_badidx();
    t_multi();
    t_mode_lock();
    t_extreme();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule